// File: doc/BRIEF.md
# Integer ALU with Shared Branch Comparator

This is a purely combinational execute unit for a 32-bit integer pipeline. It takes two operands. The first always comes from a register. The second is either a register value or an immediate, and the caller chooses which. The unit produces one result word.

A 3-bit operation field picks the function. A 7-bit qualifier field refines that choice: its bit 5 turns add into subtract and a logical right shift into an arithmetic one.

A mode input reuses the same 3-bit field as a branch-condition code. In that mode the unit answers taken (1) or not taken (0) in bit 0, and every other result bit is zero. Operand muxing, the register file and next-PC logic sit outside the block.

The caller is expected to prepare the qualifier field for immediate forms:
- For immediate shifts, pass the upper immediate bits so that an arithmetic right shift can be told apart.
- For add-immediate, pass zero so that no subtract is implied.

Top module: `alu_branch_unit`

## Requirements
- R1: With `is_branch_i`=0 and `funct3_i`=000, `result_o` is a+b when `funct7_i[5]`=0, and a-b (modulo 2^32) when `funct7_i[5]`=1.
- R2: With `funct3_i`=001 (ALU mode), `result_o` is a shifted left by `op_b_i[4:0]`, filling with zeros. The upper 27 bits of b are ignored.
- R3: With `funct3_i`=101 (ALU mode), `result_o` is a shifted right by `op_b_i[4:0]`. The fill is zero when `funct7_i[5]`=0 and copies of a[31] when `funct7_i[5]`=1.
- R4: Code 010 returns 1 if a<b as signed two's-complement numbers, otherwise 0. Code 011 does the same comparison as unsigned numbers.
- R5: Code 100 returns a XOR b, code 110 returns a OR b, and code 111 returns a AND b, bit by bit.
- R6: With `is_branch_i`=1, code 000 returns 1 when a==b, and code 001 returns 1 when a!=b.
- R7: In branch mode, code 100 returns 1 when a<b signed, and code 101 returns 1 when a>=b signed.
- R8: In branch mode, code 110 returns 1 when a<b unsigned, and code 111 returns 1 when a>=b unsigned.
- R9: In branch mode, `result_o[31:1]` is always 0. Codes 010 and 011 return 0.
- R10: Only bit 5 of `funct7_i` is examined, and only for codes 000 and 101 in ALU mode. Every other qualifier value has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| is_branch_i | input | 1 | 1 selects branch-condition mode |
| funct3_i | input | 3 | Operation or branch-condition code |
| funct7_i | input | 7 | Qualifier; bit 5 selects subtract / arithmetic shift |
| op_a_i | input | 32 | First operand (register) |
| op_b_i | input | 32 | Second operand (register or immediate) |
| result_o | output | 32 | Result word, or taken flag in bit 0 |

## Verification
The bench builds the unit at its default 32-bit width. It sweeps a cross product of:
- a set of edge operands: zero, one, sign boundaries, all-ones, values around shift amount 31/32, and mixed patterns;
- every code in both modes;
- four qualifier values.

The edge operands bring within reach carry and borrow wrap, signed versus unsigned disagreement at the sign bit, shift amounts that need masking, and sign fill on right shifts. The two unused qualifier values check that extra qualifier bits have no effect.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned FUNCT7_ALT_BIT = 5;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SLL  = 3'b001,
    OP_SLT  = 3'b010,
    OP_SLTU = 3'b011,
    OP_XOR  = 3'b100,
    OP_SR   = 3'b101,
    OP_OR   = 3'b110,
    OP_AND  = 3'b111
  } alu_op_e;

  typedef enum logic [2:0] {
    BR_EQ  = 3'b000,
    BR_NE  = 3'b001,
    BR_RSV0 = 3'b010,
    BR_RSV1 = 3'b011,
    BR_LT  = 3'b100,
    BR_GE  = 3'b101,
    BR_LTU = 3'b110,
    BR_GEU = 3'b111
  } br_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o
);
  logic [DATA_W-1:0] b_eff;
  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + DATA_W'(sub_i);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               right_i,
  input  logic               arith_i,
  output logic [DATA_W-1:0]  y_o
);
  logic signed [DATA_W-1:0] a_s;
  logic signed [DATA_W-1:0] sra;
  assign a_s = a_i;
  assign sra = a_s >>> shamt_i;

  always_comb begin
    if (!right_i)     y_o = a_i << shamt_i;
    else if (arith_i) y_o = $unsigned(sra);
    else              y_o = a_i >> shamt_i;
  end

  always_comb begin
    AST_SHIFT_ZERO_IDENT: assert (shamt_i != '0 || y_o == a_i) else $error("zero shift altered operand"); // R2
  end
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              eq_o,
  output logic              lt_s_o,
  output logic              lt_u_o
);
  localparam int unsigned MSB = DATA_W - 1;

  assign eq_o   = (a_i == b_i);
  assign lt_u_o = (a_i < b_i);
  // signs differ: negative operand is smaller
  assign lt_s_o = (a_i[MSB] != b_i[MSB]) ? a_i[MSB] : lt_u_o;

  always_comb begin
    AST_LT_EXCLUDES_EQ: assert (!(eq_o && (lt_s_o || lt_u_o))) else $error("equal operands reported as less"); // R7
  end
endmodule

// File: rtl/alu_branch_unit.sv
module alu_branch_unit #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              is_branch_i,
  input  logic [2:0]        funct3_i,
  input  logic [6:0]        funct7_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  output logic [DATA_W-1:0] result_o
);
  import alu_pkg::*;

  localparam int unsigned SHAMT_W = $clog2(DATA_W);

  logic              alt;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] shifted;
  logic              cmp_eq, cmp_lt_s, cmp_lt_u;
  logic              taken;
  logic              unused_f7;

  assign alt       = funct7_i[FUNCT7_ALT_BIT];
  assign unused_f7 = ^{funct7_i[6], funct7_i[4:0]};

  alu_addsub #(.DATA_W(DATA_W)) i_addsub (
    .a_i   (op_a_i),
    .b_i   (op_b_i),
    .sub_i (alt),
    .sum_o (sum)
  );

  alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) i_shifter (
    .a_i     (op_a_i),
    .shamt_i (op_b_i[SHAMT_W-1:0]),
    .right_i (funct3_i[2]),
    .arith_i (alt),
    .y_o     (shifted)
  );

  alu_compare #(.DATA_W(DATA_W)) i_compare (
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .eq_o   (cmp_eq),
    .lt_s_o (cmp_lt_s),
    .lt_u_o (cmp_lt_u)
  );

  always_comb begin
    unique case (br_op_e'(funct3_i))
      BR_EQ:   taken = cmp_eq;
      BR_NE:   taken = !cmp_eq;
      BR_LT:   taken = cmp_lt_s;
      BR_GE:   taken = !cmp_lt_s;
      BR_LTU:  taken = cmp_lt_u;
      BR_GEU:  taken = !cmp_lt_u;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    result_o = '0;
    if (is_branch_i) begin
      result_o[0] = taken;
    end else begin
      unique case (alu_op_e'(funct3_i))
        OP_ADD:  result_o = sum;
        OP_SLL:  result_o = shifted;
        OP_SLT:  result_o[0] = cmp_lt_s;
        OP_SLTU: result_o[0] = cmp_lt_u;
        OP_XOR:  result_o = op_a_i ^ op_b_i;
        OP_SR:   result_o = shifted;
        OP_OR:   result_o = op_a_i | op_b_i;
        OP_AND:  result_o = op_a_i & op_b_i;
        default: result_o = '0;
      endcase
    end
  end

  always_comb begin
    AST_BRANCH_UPPER_ZERO: assert (!is_branch_i || result_o[DATA_W-1:1] == '0) else $error("branch result upper bits set"); // R9
    AST_BRANCH_RSV_ZERO: assert (!(is_branch_i && funct3_i[2:1] == 2'b01) || result_o == '0) else $error("reserved branch code taken"); // R9
    AST_SUB_ZERO_IS_EQ: assert (!(!is_branch_i && funct3_i == 3'b000 && alt) || ((result_o == '0) == cmp_eq)) else $error("difference disagrees with comparator"); // R1
    AST_SLT_BOOLEAN: assert (!(!is_branch_i && funct3_i[2:1] == 2'b01) || result_o[DATA_W-1:1] == '0) else $error("set-less-than wider than one bit"); // R4
  end
endmodule

// File: tb/test_alu_branch_unit.sv
module test_alu_branch_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         is_branch;
  logic [2:0]   funct3;
  logic [6:0]   funct7;
  logic [W-1:0] op_a, op_b, result;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_branch_unit #(.DATA_W(W)) i_alu_branch_unit (
    .is_branch_i (is_branch),
    .funct3_i    (funct3),
    .funct7_i    (funct7),
    .op_a_i      (op_a),
    .op_b_i      (op_b),
    .result_o    (result)
  );

  function automatic logic [W-1:0] model(input logic br, input logic [2:0] f3,
                                         input logic [6:0] f7, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    logic [4:0] sh;
    logic       slt, sltu;
    sh   = b[4:0];
    sltu = a < b;
    slt  = $signed(a) < $signed(b);
    if (br) begin
      case (f3)
        3'b000: return {31'b0, a == b};
        3'b001: return {31'b0, a != b};
        3'b100: return {31'b0, slt};
        3'b101: return {31'b0, !slt};
        3'b110: return {31'b0, sltu};
        3'b111: return {31'b0, !sltu};
        default: return '0;
      endcase
    end
    case (f3)
      3'b000: return f7[5] ? a - b : a + b;
      3'b001: return a << sh;
      3'b010: return {31'b0, slt};
      3'b011: return {31'b0, sltu};
      3'b100: return a ^ b;
      3'b101: return f7[5] ? $unsigned($signed(a) >>> sh) : a >> sh;
      3'b110: return a | b;
      default: return a & b;
    endcase
  endfunction

  function automatic string req_tag(input logic br, input logic [2:0] f3, input logic [6:0] f7);
    if (br) begin
      case (f3)
        3'b000, 3'b001: return "R6";
        3'b100, 3'b101: return "R7";
        3'b110, 3'b111: return "R8";
        default:        return "R9";
      endcase
    end
    if (f7 != 7'h00 && f7 != 7'h20) return "R10";
    case (f3)
      3'b000:                 return "R1";
      3'b001:                 return "R2";
      3'b101:                 return "R3";
      3'b010, 3'b011:         return "R4";
      default:                return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] exp);
    n_chk++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s br=%0b f3=%03b f7=%02h a=%08h b=%08h actual=%08h expected=%08h",
               tag, is_branch, funct3, funct7, op_a, op_b, result, exp);
    end
  endtask

  task automatic apply(input logic br, input logic [2:0] f3, input logic [6:0] f7,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk);
    is_branch = br; funct3 = f3; funct7 = f7; op_a = a; op_b = b;
    @(negedge clk);
    check(req_tag(br, f3, f7), model(br, f3, f7, a, b));
  endtask

  logic [W-1:0] vals [12];
  logic [6:0]   quals [4];

  initial begin
    vals = '{32'h0, 32'h1, 32'h2, 32'h7fffffff, 32'h80000000, 32'hffffffff,
             32'h1f, 32'h20, 32'h21, 32'h12345678, 32'hdeadbeef, 32'h5a5a5a5a};
    quals = '{7'h00, 7'h20, 7'h01, 7'h5f};
    is_branch = 1'b0; funct3 = '0; funct7 = '0; op_a = '0; op_b = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", '0); // all-zero inputs give zero

    // directed corners
    apply(1'b0, 3'b000, 7'h20, 32'h0, 32'h1);          // R1 borrow wrap
    apply(1'b0, 3'b001, 7'h00, 32'h1, 32'hffffffe1);   // R2 mask upper b
    apply(1'b0, 3'b101, 7'h20, 32'h80000000, 32'h3f);  // R3 sign fill by 31
    apply(1'b1, 3'b011, 7'h00, 32'h5, 32'h5);          // R9 reserved code
    apply(1'b0, 3'b100, 7'h20, 32'hf0f0f0f0, 32'h0ff00ff0); // R10 qualifier on xor

    for (int br = 0; br < 2; br++)
      for (int f3 = 0; f3 < 8; f3++)
        for (int q = 0; q < 4; q++)
          for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
              apply(br[0], f3[2:0], quals[q], vals[i], vals[j]);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule